// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between the load/store pipeline of an out-of-order core and a single data-cache write port. Stores take an entry in program order when they are dispatched. Their address and data arrive later and in any order, each tagged with the entry index. Stores are committed oldest first. A committed store stays in its entry until the cache write port accepts it, and stores leave strictly in program order. Because the cache is written only by committed stores, memory state stays precise.

Each load is presented on a lookup port with its address and its age. The age is the value the allocation tag had when the load was dispatched, so every buffered store allocated before that point is older than the load. The block answers in the same cycle with one of three results. Bypass sends the load to the cache. Forward supplies the data of the youngest older store with the same address, and the cache access is suppressed. Hold tells the load to retry later.

A store address may be written with only its untranslated page-offset bits known. Such an address can prove that a load does not alias, but it cannot prove that it does. A flush throws away every uncommitted store and keeps the committed ones until they drain.

Top module: `sb_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready`=1, `alloc_tag`=0 and `dc_valid`=0. Each accepted allocation advances `alloc_tag` by one, modulo twice DEPTH (8 by default). With DEPTH entries occupied, `alloc_ready` is 0 and a further allocation request is ignored.
- R2: `dc_valid` is asserted only for the oldest entry, only when it is committed and has full address and data. `dc_addr`/`dc_data` stay stable while `dc_ready` is low. Entries drain in program order, and an uncommitted store is never presented.
- R3: A load whose older stores all have known addresses, none matching, gets result bypass (2'b00) and `ld_cache_req`=1.
- R4: A load with any older store whose address is still unknown gets result hold (2'b10), whatever the addresses.
- R5: When older stores match the load address in full, the youngest of them supplies `ld_data`, the result is forward (2'b01) and `ld_cache_req`=0.
- R6: When the youngest older matching store has no data yet, the result is hold.
- R7: A store address marked offset-only is compared on its low OFS_W (12) bits. A mismatch allows bypass and a match gives hold, never forward. Such a store is not drained until a full address is written.
- R8: Stores allocated at or after the load's age play no part in its lookup.
- R9: `flush` resets the allocation tag to the first uncommitted entry. All uncommitted stores are discarded, while committed stores remain and still drain. Commit and allocation requests in the flush cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one store entry |
| alloc_ready | output | 1 | A free entry exists |
| alloc_tag | output | IDX_W+1 | Tag (with wrap bit) the next allocation receives; also the age for loads |
| addr_wr_valid | input | 1 | Write a store address |
| addr_wr_tag | input | IDX_W | Entry written |
| addr_wr_addr | input | AW | Store address |
| addr_wr_ofs_only | input | 1 | Only the low OFS_W bits are valid |
| data_wr_valid | input | 1 | Write store data |
| data_wr_tag | input | IDX_W | Entry written |
| data_wr_data | input | DW | Store data |
| commit_valid | input | 1 | Commit the oldest uncommitted store |
| flush | input | 1 | Discard all uncommitted stores |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | AW | Load address |
| ld_age | input | IDX_W+1 | Allocation tag seen when the load was dispatched |
| ld_res | output | 2 | 00 bypass, 01 forward, 10 hold |
| ld_data | output | DW | Forwarded data, zero otherwise |
| ld_cache_req | output | 1 | Load may access the cache |
| dc_valid | output | 1 | Cache write request |
| dc_ready | input | 1 | Cache write accepted |
| dc_addr | output | AW | Cache write address |
| dc_data | output | DW | Cache write data |

## Verification
The checker watches several properties on every cycle. It checks that the cache write port only ever carries a committed entry and holds still under backpressure. It checks that a full buffer refuses allocation and that a forwarding or holding load never raises a cache request. It also checks that a flush pulls the allocation pointer back to the commit point and that the commit pointer never passes the tail. Which store supplies forwarded data, how lookups treat unresolved, offset-only and younger stores, and the drain order after a flush all depend on the history of writes. Only the bench scenarios show these, by comparing results against values worked out by hand.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [1:0] {
        SB_BYP  = 2'b00,
        SB_FWD  = 2'b01,
        SB_HOLD = 2'b10
    } sb_res_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PTR_W = IDX_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    output logic                         alloc_ready,
    input  logic                         addr_wr_valid,
    input  logic [IDX_W-1:0]             addr_wr_tag,
    input  logic [AW-1:0]                addr_wr_addr,
    input  logic                         addr_wr_ofs_only,
    input  logic                         data_wr_valid,
    input  logic [IDX_W-1:0]             data_wr_tag,
    input  logic [DW-1:0]                data_wr_data,
    input  logic                         commit_valid,
    input  logic                         flush,
    input  logic                         dc_ready,
    output logic                         dc_valid,
    output logic [AW-1:0]                dc_addr,
    output logic [DW-1:0]                dc_data,
    output logic [PTR_W-1:0]             head_ptr,
    output logic [PTR_W-1:0]             cmt_ptr,
    output logic [PTR_W-1:0]             tail_ptr,
    output logic [DEPTH-1:0]             e_addr_ok,
    output logic [DEPTH-1:0]             e_ofs_only,
    output logic [DEPTH-1:0]             e_data_ok,
    output logic [DEPTH-1:0][AW-1:0]     e_addr,
    output logic [DEPTH-1:0][DW-1:0]     e_data
);
    typedef struct packed {
        logic [PTR_W-1:0]         head;
        logic [PTR_W-1:0]         cmt;
        logic [PTR_W-1:0]         tail;
        logic [DEPTH-1:0]         aok;
        logic [DEPTH-1:0]         ofs;
        logic [DEPTH-1:0]         dok;
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
    } sq_state_t;

    sq_state_t st_q, st_d;

    logic [PTR_W-1:0] occ;
    logic [IDX_W-1:0] head_idx, tail_idx;
    logic             full, has_committed, drain_ok, drain_fire;

    assign occ           = st_q.tail - st_q.head;
    assign full          = (occ == PTR_W'(DEPTH));
    assign head_idx      = st_q.head[IDX_W-1:0];
    assign tail_idx      = st_q.tail[IDX_W-1:0];
    assign has_committed = (st_q.cmt != st_q.head);
    assign drain_ok      = has_committed && st_q.aok[head_idx] &&
                           !st_q.ofs[head_idx] && st_q.dok[head_idx];
    assign drain_fire    = drain_ok && dc_ready;

    always_comb begin
        st_d = st_q;
        if (addr_wr_valid) begin
            st_d.aok[addr_wr_tag]  = 1'b1;
            st_d.ofs[addr_wr_tag]  = addr_wr_ofs_only;
            st_d.addr[addr_wr_tag] = addr_wr_addr;
        end
        if (data_wr_valid) begin
            st_d.dok[data_wr_tag]  = 1'b1;
            st_d.data[data_wr_tag] = data_wr_data;
        end
        if (drain_fire) begin
            st_d.head = st_q.head + PTR_W'(1);
        end
        if (flush) begin
            st_d.tail = st_q.cmt;
        end else begin
            if (commit_valid && (st_q.cmt != st_q.tail)) begin
                st_d.cmt = st_q.cmt + PTR_W'(1);
            end
            if (alloc_valid && !full) begin
                st_d.aok[tail_idx] = 1'b0;
                st_d.ofs[tail_idx] = 1'b0;
                st_d.dok[tail_idx] = 1'b0;
                st_d.tail          = st_q.tail + PTR_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_ready = !full;
    assign dc_valid    = drain_ok;
    assign dc_addr     = st_q.addr[head_idx];
    assign dc_data     = st_q.data[head_idx];
    assign head_ptr    = st_q.head;
    assign cmt_ptr     = st_q.cmt;
    assign tail_ptr    = st_q.tail;
    assign e_addr_ok   = st_q.aok;
    assign e_ofs_only  = st_q.ofs;
    assign e_data_ok   = st_q.dok;
    assign e_addr      = st_q.addr;
    assign e_data      = st_q.data;
endmodule

// File: rtl/sb_lookup.sv
module sb_lookup
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFS_W = 12,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PTR_W = IDX_W + 1
) (
    input  logic [PTR_W-1:0]         head_ptr,
    input  logic [PTR_W-1:0]         tail_ptr,
    input  logic [DEPTH-1:0]         e_addr_ok,
    input  logic [DEPTH-1:0]         e_ofs_only,
    input  logic [DEPTH-1:0]         e_data_ok,
    input  logic [DEPTH-1:0][AW-1:0] e_addr,
    input  logic [DEPTH-1:0][DW-1:0] e_data,
    input  logic [AW-1:0]            ld_addr,
    input  logic [PTR_W-1:0]         ld_age,
    output sb_res_e                  ld_res,
    output logic [DW-1:0]            ld_data
);
    logic [PTR_W-1:0] occ, span;
    logic [IDX_W-1:0] idx, hit_idx;
    logic             unresolved, hit, match;

    always_comb begin
        occ  = tail_ptr - head_ptr;
        span = ld_age - head_ptr;
        if (span > occ) span = occ;
        unresolved = 1'b0;
        hit        = 1'b0;
        hit_idx    = '0;
        idx        = '0;
        match      = 1'b0;
        // scan oldest to youngest; the last match is the youngest older store
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_ptr[IDX_W-1:0] + IDX_W'(k);
            if (PTR_W'(k) < span) begin
                if (!e_addr_ok[idx]) begin
                    unresolved = 1'b1;
                end else begin
                    if (e_ofs_only[idx]) begin
                        match = (e_addr[idx][OFS_W-1:0] == ld_addr[OFS_W-1:0]);
                    end else begin
                        match = (e_addr[idx] == ld_addr);
                    end
                    if (match) begin
                        hit     = 1'b1;
                        hit_idx = idx;
                    end
                end
            end
        end
        ld_data = '0;
        if (unresolved) begin
            ld_res = SB_HOLD;
        end else if (hit) begin
            if (e_ofs_only[hit_idx] || !e_data_ok[hit_idx]) begin
                ld_res = SB_HOLD;
            end else begin
                ld_res  = SB_FWD;
                ld_data = e_data[hit_idx];
            end
        end else begin
            ld_res = SB_BYP;
        end
    end
endmodule

// File: rtl/sb_store_buffer.sv
module sb_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int OFS_W = 12,
    parameter int IDX_W = $clog2(DEPTH),
    parameter int PTR_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    output logic             alloc_ready,
    output logic [PTR_W-1:0] alloc_tag,
    input  logic             addr_wr_valid,
    input  logic [IDX_W-1:0] addr_wr_tag,
    input  logic [AW-1:0]    addr_wr_addr,
    input  logic             addr_wr_ofs_only,
    input  logic             data_wr_valid,
    input  logic [IDX_W-1:0] data_wr_tag,
    input  logic [DW-1:0]    data_wr_data,
    input  logic             commit_valid,
    input  logic             flush,
    input  logic             ld_valid,
    input  logic [AW-1:0]    ld_addr,
    input  logic [PTR_W-1:0] ld_age,
    output logic [1:0]       ld_res,
    output logic [DW-1:0]    ld_data,
    output logic             ld_cache_req,
    output logic             dc_valid,
    input  logic             dc_ready,
    output logic [AW-1:0]    dc_addr,
    output logic [DW-1:0]    dc_data
);
    logic [PTR_W-1:0]         head_ptr, cmt_ptr, tail_ptr;
    logic [DEPTH-1:0]         e_addr_ok, e_ofs_only, e_data_ok;
    logic [DEPTH-1:0][AW-1:0] e_addr;
    logic [DEPTH-1:0][DW-1:0] e_data;
    sb_res_e                  res;

    sb_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_queue (
        .clk              (clk),
        .rst_n            (rst_n),
        .alloc_valid      (alloc_valid),
        .alloc_ready      (alloc_ready),
        .addr_wr_valid    (addr_wr_valid),
        .addr_wr_tag      (addr_wr_tag),
        .addr_wr_addr     (addr_wr_addr),
        .addr_wr_ofs_only (addr_wr_ofs_only),
        .data_wr_valid    (data_wr_valid),
        .data_wr_tag      (data_wr_tag),
        .data_wr_data     (data_wr_data),
        .commit_valid     (commit_valid),
        .flush            (flush),
        .dc_ready         (dc_ready),
        .dc_valid         (dc_valid),
        .dc_addr          (dc_addr),
        .dc_data          (dc_data),
        .head_ptr         (head_ptr),
        .cmt_ptr          (cmt_ptr),
        .tail_ptr         (tail_ptr),
        .e_addr_ok        (e_addr_ok),
        .e_ofs_only       (e_ofs_only),
        .e_data_ok        (e_data_ok),
        .e_addr           (e_addr),
        .e_data           (e_data)
    );

    sb_lookup #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .OFS_W(OFS_W)) i_lookup (
        .head_ptr   (head_ptr),
        .tail_ptr   (tail_ptr),
        .e_addr_ok  (e_addr_ok),
        .e_ofs_only (e_ofs_only),
        .e_data_ok  (e_data_ok),
        .e_addr     (e_addr),
        .e_data     (e_data),
        .ld_addr    (ld_addr),
        .ld_age     (ld_age),
        .ld_res     (res),
        .ld_data    (ld_data)
    );

    assign alloc_tag    = tail_ptr;
    assign ld_res       = res;
    assign ld_cache_req = ld_valid && (res == SB_BYP);
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int PTR_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             flush,
    input logic             ld_valid,
    input logic [1:0]       ld_res,
    input logic             ld_cache_req,
    input logic             dc_valid,
    input logic             dc_ready,
    input logic [AW-1:0]    dc_addr,
    input logic [DW-1:0]    dc_data,
    input logic [PTR_W-1:0] head_ptr,
    input logic [PTR_W-1:0] cmt_ptr,
    input logic [PTR_W-1:0] tail_ptr
);
    p_full_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((tail_ptr - head_ptr) == PTR_W'(DEPTH)) |-> !alloc_ready);

    p_drain_committed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dc_valid |-> (cmt_ptr != head_ptr));

    p_drain_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_valid && !dc_ready) |=> (dc_valid && $stable(dc_addr) && $stable(dc_data)));

    p_cache_only_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cache_req |-> (ld_valid && ld_res == 2'b00));

    p_forward_no_cache_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_res == 2'b01) |-> !ld_cache_req);

    p_flush_rewind_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (tail_ptr == $past(cmt_ptr)));

    p_commit_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_ptr - head_ptr) <= (tail_ptr - head_ptr));
endmodule

bind sb_store_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PTR_W(PTR_W)) i_sb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_ready  (alloc_ready),
    .flush        (flush),
    .ld_valid     (ld_valid),
    .ld_res       (ld_res),
    .ld_cache_req (ld_cache_req),
    .dc_valid     (dc_valid),
    .dc_ready     (dc_ready),
    .dc_addr      (dc_addr),
    .dc_data      (dc_data),
    .head_ptr     (head_ptr),
    .cmt_ptr      (cmt_ptr),
    .tail_ptr     (tail_ptr)
);

// File: tb/test_sb_store_buffer.sv
module test_sb_store_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 8;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int IDX_W = 3;
    localparam int PTR_W = 4;
    localparam logic [1:0] BYP = 2'b00, FWD = 2'b01, HOLD = 2'b10;

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [PTR_W-1:0] age;
        logic [1:0]       res;
        logic [DW-1:0]    data;
    } vec_t;

    // stores: tag0 0x100/A0, tag1 0x200/B1, tag2 0x100/C2, tag3 address unknown
    localparam vec_t VEC [8] = '{
        '{32'h100, 4'd0, BYP,  32'h0},   // R8 R3: nothing older
        '{32'h100, 4'd1, FWD,  32'hA0},  // R5
        '{32'h100, 4'd3, FWD,  32'hC2},  // R5 youngest older match
        '{32'h200, 4'd3, FWD,  32'hB1},  // R5
        '{32'h300, 4'd3, BYP,  32'h0},   // R3 no match
        '{32'h300, 4'd4, HOLD, 32'h0},   // R4 tag3 unresolved
        '{32'h300, 4'd2, BYP,  32'h0},   // R8 tag2/tag3 younger
        '{32'h200, 4'd1, BYP,  32'h0}    // R8 tag1 younger
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, addr_wr_valid = 0, addr_wr_ofs_only = 0, data_wr_valid = 0;
    logic commit_valid = 0, flush = 0, ld_valid = 0, dc_ready = 0;
    logic [IDX_W-1:0] addr_wr_tag = '0, data_wr_tag = '0;
    logic [AW-1:0] addr_wr_addr = '0, ld_addr = '0;
    logic [DW-1:0] data_wr_data = '0;
    logic [PTR_W-1:0] ld_age = '0;
    logic alloc_ready, ld_cache_req, dc_valid;
    logic [PTR_W-1:0] alloc_tag;
    logic [1:0] ld_res;
    logic [DW-1:0] ld_data, dc_data;
    logic [AW-1:0] dc_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sb_store_buffer i_sb_store_buffer (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .addr_wr_valid(addr_wr_valid), .addr_wr_tag(addr_wr_tag),
        .addr_wr_addr(addr_wr_addr), .addr_wr_ofs_only(addr_wr_ofs_only),
        .data_wr_valid(data_wr_valid), .data_wr_tag(data_wr_tag), .data_wr_data(data_wr_data),
        .commit_valid(commit_valid), .flush(flush),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_age(ld_age),
        .ld_res(ld_res), .ld_data(ld_data), .ld_cache_req(ld_cache_req),
        .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_addr(dc_addr), .dc_data(dc_data)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        alloc_valid = 0; addr_wr_valid = 0; data_wr_valid = 0;
        commit_valid = 0; flush = 0;
    endtask

    task automatic wr_addr(input int tag, input logic [AW-1:0] a, input logic ofs);
        addr_wr_valid = 1; addr_wr_tag = IDX_W'(tag); addr_wr_addr = a; addr_wr_ofs_only = ofs;
        tick();
    endtask

    task automatic wr_data(input int tag, input logic [DW-1:0] d);
        data_wr_valid = 1; data_wr_tag = IDX_W'(tag); data_wr_data = d;
        tick();
    endtask

    task automatic lookup(input string req, input logic [AW-1:0] a, input logic [PTR_W-1:0] age,
                          input logic [1:0] er, input logic [DW-1:0] ed);
        ld_valid = 1; ld_addr = a; ld_age = age;
        #1;
        chk(req, {62'd0, ld_res}, {62'd0, er});
        chk(req, {32'd0, ld_data}, {32'd0, ed});
        chk(req, {63'd0, ld_cache_req}, {63'd0, (er == BYP)});
        ld_valid = 0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 ready", {63'd0, alloc_ready}, 64'd1);
        chk("R1 tag", {60'd0, alloc_tag}, 64'd0);
        chk("R1 drain idle", {63'd0, dc_valid}, 64'd0);

        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1;
            tick();
        end
        chk("R1 tag after 4", {60'd0, alloc_tag}, 64'd4);
        wr_addr(0, 32'h100, 0); wr_data(0, 32'hA0);
        wr_addr(1, 32'h200, 0); wr_data(1, 32'hB1);
        wr_addr(2, 32'h100, 0); wr_data(2, 32'hC2);

        foreach (VEC[i]) begin
            lookup($sformatf("R3/R4/R5/R8 vec%0d", i), VEC[i].addr, VEC[i].age, VEC[i].res, VEC[i].data);
        end

        // R6: tag3 address known and matching, data absent
        wr_addr(3, 32'h300, 0);
        lookup("R6 match without data", 32'h300, 4'd4, HOLD, 32'h0);
        lookup("R3 resolved no match", 32'h400, 4'd4, BYP, 32'h0);

        // R7: offset-only address on tag3
        wr_addr(3, 32'h0000_0300, 1);
        wr_data(3, 32'hD3);
        lookup("R7 offset match holds", 32'h0000_7300, 4'd4, HOLD, 32'h0);
        lookup("R7 offset mismatch bypasses", 32'h0000_7400, 4'd4, BYP, 32'h0);

        // R1: fill to DEPTH
        for (int i = 0; i < 4; i++) begin
            alloc_valid = 1;
            tick();
        end
        chk("R1 full stalls", {63'd0, alloc_ready}, 64'd0);
        chk("R1 tag at full", {60'd0, alloc_tag}, 64'd8);
        alloc_valid = 1;
        tick();
        chk("R1 alloc ignored when full", {60'd0, alloc_tag}, 64'd8);

        // R2: drain order and backpressure
        chk("R2 nothing committed", {63'd0, dc_valid}, 64'd0);
        commit_valid = 1;
        tick();
        chk("R2 head valid", {63'd0, dc_valid}, 64'd1);
        chk("R2 head addr", {32'd0, dc_addr}, 64'h100);
        chk("R2 head data", {32'd0, dc_data}, 64'hA0);
        commit_valid = 1;
        tick();
        chk("R2 held addr", {32'd0, dc_addr}, 64'h100);
        chk("R2 held data", {32'd0, dc_data}, 64'hA0);
        dc_ready = 1;
        tick();
        chk("R2 second addr", {32'd0, dc_addr}, 64'h200);
        chk("R2 second data", {32'd0, dc_data}, 64'hB1);
        tick();
        dc_ready = 0;
        chk("R2 uncommitted not drained", {63'd0, dc_valid}, 64'd0);

        // R9: commit tag2 then flush
        commit_valid = 1;
        tick();
        flush = 1; alloc_valid = 1;
        tick();
        chk("R9 tag rewound", {60'd0, alloc_tag}, 64'd3);
        chk("R9 room again", {63'd0, alloc_ready}, 64'd1);
        chk("R9 committed kept valid", {63'd0, dc_valid}, 64'd1);
        chk("R9 committed kept data", {32'd0, dc_data}, 64'hC2);
        lookup("R9 discarded store ignored", 32'h0000_7300, 4'd3, BYP, 32'h0);
        dc_ready = 1;
        tick();
        dc_ready = 0;
        chk("R9 drained empty", {63'd0, dc_valid}, 64'd0);

        // R7: offset-only committed store waits for full address
        alloc_valid = 1;
        tick();
        wr_addr(3, 32'h0000_0500, 1);
        wr_data(3, 32'hE3);
        commit_valid = 1;
        tick();
        chk("R7 offset-only not drained", {63'd0, dc_valid}, 64'd0);
        wr_addr(3, 32'h0001_0500, 0);
        chk("R7 drains after full addr", {63'd0, dc_valid}, 64'd1);
        chk("R7 drain addr", {32'd0, dc_addr}, 64'h10500);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule